// File: doc/BRIEF.md
# Fast Context Shadow Store

This block keeps a single saved copy of three core registers: the status flags, the working accumulator and the bank select value. Two events fill it. Entry into any interrupt fills it on its own. A subroutine call that carries the fast option fills it on request. Two other events play the saved copy back to the core, each one cycle after it is seen: a subroutine return with the fast option, and an interrupt return with the fast option. Each playback raises a one-cycle load strobe next to the three values.

The copy is one level deep. No bus can read it or write it. Each new interrupt entry replaces whatever it held, so a high-priority interrupt that nests inside a low-priority handler destroys the values the first entry saved. A plain return with no fast option does nothing. If a fill and a playback land in the same cycle, the playback delivers the values held before the fill.

Top module: `fast_ctx_shadow`

## Requirements
- R1: After synchronous reset the load strobe is 0, the restore outputs are 0, and the saved copy is 0. A fast restore made right after reset returns all zeros.
- R2: When `irq_vec` is 1 at a clock edge, the live status, accumulator and bank values are stored as the saved copy. The interrupt source and priority make no difference.
- R3: When `call_req` and `call_fast` are both 1 at a clock edge, the live values are stored as the saved copy. A call with `call_fast` at 0 stores nothing.
- R4: When `ret_req` and `ret_fast` are both 1 at a clock edge, then from that edge `rst_load` is 1 for one cycle and the restore outputs carry the saved copy as it stood before that edge.
- R5: When `iret_req` and `iret_fast` are both 1 at a clock edge, the outputs behave as in R4.
- R6: A return with its fast input at 0 (`iret_req` or `ret_req` alone) leaves `rst_load` at 0 and keeps the restore outputs unchanged.
- R7: Storage is one level deep. A second capture overwrites the first, and any later restore returns only the second set of values.
- R8: When a capture and a restore are requested at the same edge, the restore outputs carry the old saved copy. The new values come out at the next restore.
- R9: A restore request raises `rst_load` for exactly one cycle. Requests on consecutive edges keep it high on each of those cycles.
- R10: On an edge with no restore request, `rst_load` goes to 0 and the restore outputs hold their values. On an edge with no capture, the saved copy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_vec | input | 1 | Interrupt entry (capture) |
| call_req | input | 1 | Subroutine call executing |
| call_fast | input | 1 | Call carries the fast-save option |
| ret_req | input | 1 | Subroutine return executing |
| ret_fast | input | 1 | Return carries the fast-restore option |
| iret_req | input | 1 | Interrupt return executing |
| iret_fast | input | 1 | Interrupt return carries the fast-restore option |
| live_stat | input | STAT_W | Live status register |
| live_acc | input | ACC_W | Live working accumulator |
| live_bank | input | BANK_W | Live bank select register |
| rst_load | output | 1 | One-cycle load strobe for the core registers |
| rst_stat | output | STAT_W | Restored status value |
| rst_acc | output | ACC_W | Restored accumulator value |
| rst_bank | output | BANK_W | Restored bank select value |

## Verification
The bench sweeps all 128 combinations of the seven strobe inputs, several times over. On each step the live register values change arithmetically, so every capture stores a different value from the one before. This separates a fast call from a plain call, and a fast return from a plain return. It also separates capture from restore when both land in the same cycle, and shows whether old or new values come out. Directed sequences then cover:
- the values read back straight after reset,
- a nested interrupt entry overwriting the first save,
- back-to-back restores.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  // Decoded per-cycle command for the shadow store
  typedef struct packed {
    logic capture;
    logic restore;
  } fcs_cmd_t;
endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import fcs_pkg::*;
(
  input  logic     irq_vec,
  input  logic     call_req,
  input  logic     call_fast,
  input  logic     ret_req,
  input  logic     ret_fast,
  input  logic     iret_req,
  input  logic     iret_fast,
  output fcs_cmd_t cmd
);
  always_comb begin
    cmd.capture = irq_vec | (call_req & call_fast);
    cmd.restore = (ret_req & ret_fast) | (iret_req & iret_fast);
  end
endmodule

// File: rtl/fcs_shadow_store.sv
module fcs_shadow_store #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] live,
  output logic [W-1:0] saved
);
  always_ff @(posedge clk) begin
    if (rst)          saved <= '0;
    else if (capture) saved <= live;
  end

  a_r2_capture_takes_live: assert property (@(posedge clk) disable iff (rst)
    capture |=> (saved == $past(live)));
  a_r10_hold_without_capture: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(saved));
endmodule

// File: rtl/fcs_restore_drive.sv
module fcs_restore_drive #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restore,
  input  logic [W-1:0] saved,
  output logic         load,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load  <= 1'b0;
      value <= '0;
    end else begin
      load <= restore;
      if (restore) value <= saved;
    end
  end

  a_r9_strobe_follows_request: assert property (@(posedge clk) disable iff (rst)
    restore |=> load);
  a_r10_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
    !restore |=> !load);
  a_r4_old_copy_delivered: assert property (@(posedge clk) disable iff (rst)
    restore |=> (value == $past(saved)));
  a_r6_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    !restore |=> $stable(value));
endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
  import fcs_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int ACC_W  = 8,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_vec,
  input  logic              call_req,
  input  logic              call_fast,
  input  logic              ret_req,
  input  logic              ret_fast,
  input  logic              iret_req,
  input  logic              iret_fast,
  input  logic [STAT_W-1:0] live_stat,
  input  logic [ACC_W-1:0]  live_acc,
  input  logic [BANK_W-1:0] live_bank,
  output logic              rst_load,
  output logic [STAT_W-1:0] rst_stat,
  output logic [ACC_W-1:0]  rst_acc,
  output logic [BANK_W-1:0] rst_bank
);
  localparam int CTX_W = STAT_W + ACC_W + BANK_W;

  fcs_cmd_t         cmd;
  logic [CTX_W-1:0] live_ctx;
  logic [CTX_W-1:0] saved_ctx;
  logic [CTX_W-1:0] out_ctx;

  assign live_ctx = {live_stat, live_acc, live_bank};

  fcs_cmd_decode u_dec (
    .irq_vec   (irq_vec),
    .call_req  (call_req),
    .call_fast (call_fast),
    .ret_req   (ret_req),
    .ret_fast  (ret_fast),
    .iret_req  (iret_req),
    .iret_fast (iret_fast),
    .cmd       (cmd)
  );

  fcs_shadow_store #(.W(CTX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .capture (cmd.capture),
    .live    (live_ctx),
    .saved   (saved_ctx)
  );

  fcs_restore_drive #(.W(CTX_W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .restore (cmd.restore),
    .saved   (saved_ctx),
    .load    (rst_load),
    .value   (out_ctx)
  );

  assign {rst_stat, rst_acc, rst_bank} = out_ctx;

  // R8: a restore in the same cycle as a capture delivers the pre-capture copy
  a_r8_restore_sees_old: assert property (@(posedge clk) disable iff (rst)
    (cmd.capture && cmd.restore) |=> (out_ctx == $past(saved_ctx)));
  // R6: a plain interrupt return raises no strobe
  a_r6_plain_iret_quiet: assert property (@(posedge clk) disable iff (rst)
    (iret_req && !iret_fast && !(ret_req && ret_fast)) |=> !rst_load);
endmodule

// File: tb/tb_fast_ctx_shadow.sv
module tb_fast_ctx_shadow;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8, AW = 8, BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_vec = 0, call_req = 0, call_fast = 0, ret_req = 0, ret_fast = 0;
  logic iret_req = 0, iret_fast = 0;
  logic [SW-1:0] live_stat = '0;
  logic [AW-1:0] live_acc = '0;
  logic [BW-1:0] live_bank = '0;
  logic          rst_load;
  logic [SW-1:0] rst_stat;
  logic [AW-1:0] rst_acc;
  logic [BW-1:0] rst_bank;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model, built from the requirements
  logic [SW+AW+BW-1:0] m_saved = '0;
  logic [SW+AW+BW-1:0] m_out = '0;
  logic                m_load = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_ctx_shadow #(.STAT_W(SW), .ACC_W(AW), .BANK_W(BW)) dut (
    .clk(clk), .rst(rst), .irq_vec(irq_vec), .call_req(call_req), .call_fast(call_fast),
    .ret_req(ret_req), .ret_fast(ret_fast), .iret_req(iret_req), .iret_fast(iret_fast),
    .live_stat(live_stat), .live_acc(live_acc), .live_bank(live_bank),
    .rst_load(rst_load), .rst_stat(rst_stat), .rst_acc(rst_acc), .rst_bank(rst_bank)
  );

  task automatic check(string tag);
    logic [SW+AW+BW-1:0] got;
    got = {rst_stat, rst_acc, rst_bank};
    checks++;
    if (rst_load !== m_load || got !== m_out) begin
      errors++;
      $display("FAIL %s load=%0b out=%h expected load=%0b out=%h", tag, rst_load, got, m_load, m_out);
    end
  endtask

  // One cycle: drive after the falling edge, model the rising edge, check at the next fall
  task automatic step(input logic [6:0] s, input int seed, input string tag);
    logic cap, res;
    logic [SW+AW+BW-1:0] live;
    {irq_vec, call_req, call_fast, ret_req, ret_fast, iret_req, iret_fast} = s;
    live_stat = SW'(seed * 37 + 5);
    live_acc  = AW'(seed * 113 + 71);
    live_bank = BW'(seed * 7 + 3);
    live = {live_stat, live_acc, live_bank};
    cap = s[6] | (s[5] & s[4]);
    res = (s[3] & s[2]) | (s[1] & s[0]);
    @(posedge clk);
    m_load = res;
    if (res) m_out = m_saved;
    if (cap) m_saved = live;
    @(negedge clk);
    check(tag);
  endtask

  localparam logic [6:0] IDLE  = 7'b0000000;
  localparam logic [6:0] IRQ   = 7'b1000000;
  localparam logic [6:0] CALLF = 7'b0110000;
  localparam logic [6:0] RETF  = 7'b0001100;
  localparam logic [6:0] IRETF = 7'b0000011;
  localparam logic [6:0] IRETP = 7'b0000010;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst = 0;
    // R1: restore straight after reset returns zeros
    step(RETF, 1, "R1 zero restore");
    step(IDLE, 2, "R10 idle after restore");
    // R2 then R5
    step(IRQ, 3, "R2 irq capture");
    step(IRETF, 4, "R5 fast iret restore");
    // R7: nested entry overwrites
    step(IRQ, 5, "R7 first entry");
    step(IRQ, 6, "R7 nested entry");
    step(IRETF, 7, "R7 restore sees second");
    // R3 and R4, then plain call stores nothing
    step(CALLF, 8, "R3 fast call");
    step(7'b0100000, 9, "R3 plain call");
    step(RETF, 10, "R4 fast return");
    // R6: plain returns
    step(IRETP, 11, "R6 plain iret");
    step(7'b0001000, 12, "R6 plain return");
    // R8: capture and restore together
    step(IRQ | RETF, 13, "R8 same-cycle old value");
    step(RETF, 14, "R8 new value next");
    // R9: back-to-back restores
    step(RETF, 15, "R9 back to back a");
    step(IRETF, 16, "R9 back to back b");
    step(IDLE, 17, "R9 strobe drops");
    // Exhaustive sweep over strobe inputs
    for (int pass = 0; pass < 3; pass++) begin
      for (int c = 0; c < 128; c++) begin
        logic [6:0] s;
        s = 7'(c ^ (pass * 45));
        step(s, pass * 128 + c + 20, "R2 R3 R4 R5 R6 R8 R10 sweep");
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule